// File: doc/BRIEF.md
# Subcarrier Edge-Counting Bit Receiver

This block recovers the bits a contactless card sends back to a reader. The card answers by switching a subcarrier on or off for each bit. The analogue front end reduces that to a single thresholded logic level. The receiver brings this level into the clock domain and counts its transitions inside fixed bit windows. A window whose transition count lies within the subcarrier band is read as a 1. Any other count, including a silent line, is read as a 0.

The card side has no start, stop or length marker. The reader therefore asks for a known number of bits and times every window from the moment its own frame ended. A `start` pulse, aligned to that frame-end timer reset, arms the receiver. It also captures the requested length, clamped to the word width, and an optional keystream mask. Once the last window closes, the decoded word is XORed with the mask, and the word and its length are presented with a one-cycle `rx_done` pulse. The internal timing then returns to idle, ready for the next frame.

Top module: `subcarrier_bit_rx`

## Requirements
- R1: A tick is `CLK_PER_TICK` clock cycles (default 32). The first bit window opens `LEAD_TICKS` ticks (default 490) after the clock edge that samples `start`.
- R2: Each window lasts `WIN_TICKS` ticks (default 150), and windows follow one another with no gap. For a length of n ≥ 1, `rx_done` is high in the cycle that follows the edge lying (LEAD_TICKS + n·WIN_TICKS)·CLK_PER_TICK cycles after the `start` edge.
- R3: A window decodes as 1 exactly when its transition count c satisfies `EDGE_LO` < c < `EDGE_HI` (defaults 20 and 60). Every other count decodes as 0.
- R4: The per-window transition counter saturates at its all-ones value (127 with the defaults) instead of wrapping. A window with 170 transitions therefore decodes as 0.
- R5: A requested length above `MAX_BITS` (16) is clamped to `MAX_BITS`. `rx_bits` reports the length actually received.
- R6: The bit decoded in window k is placed at bit k of `rx_data`, so the first window maps to bit 0.
- R7: When `decrypt_en` is 1 at `start`, `rx_data` is the decoded word XORed with `keystream` bits [n-1:0] as sampled at `start`. Keystream bits at n and above are ignored. When `decrypt_en` is 0, no XOR is applied. Changes to `keystream` or `decrypt_en` after `start` have no effect.
- R8: A line with no transitions decodes as all zeros.
- R9: `rx_done` is a single-cycle pulse. `rx_data` and `rx_bits` hold until the next completion. Bits of `rx_data` at `rx_bits` and above are 0.
- R10: A requested length of 0 gives `rx_done` in the cycle right after the `start` edge, with `rx_data` = 0 and `rx_bits` = 0.
- R11: After reset, `rx_done`, `rx_data` and `rx_bits` are 0.
- R12: After a frame completes, the tick timing is back at zero. A `start` issued right after `rx_done` is timed exactly as in R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_async | input | 1 | Thresholded card signal, asynchronous to clk |
| start | input | 1 | One-cycle arm pulse, aligned to the reader frame-end timer reset |
| bits_req | input | REQ_W (5) | Number of bits requested; values above MAX_BITS are clamped |
| decrypt_en | input | 1 | Apply the keystream mask to this frame |
| keystream | input | MAX_BITS (16) | Precomputed keystream mask, captured at start |
| rx_data | output | MAX_BITS (16) | Decoded (and optionally decrypted) word, first bit in bit 0 |
| rx_bits | output | BITS_W (5) | Number of bits in rx_data |
| rx_done | output | 1 | One-cycle completion pulse |

## Verification
The line is driven with nominal subcarrier bursts mixed with silent windows, to show that bits are placed least-significant first. Counts of 20, 21, 59 and 60 transitions probe each side of both band limits. A burst of 170 transitions separates a saturating counter from a wrapping one, because a wrapped count would fall back inside the band. Further frames cover a silent line, a masked frame whose keystream is scrambled after `start`, an over-long request, and a zero-length request. In every frame the cycle on which `rx_done` rises is checked, which catches a tick or window that is off by one.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_LEAD = 2'd1,
    RX_WIN  = 2'd2
  } rx_state_e;

  // Length actually received for a request.
  function automatic int clamp_len(int req, int cap);
    return (req > cap) ? cap : req;
  endfunction

  // Window decision: strictly inside the subcarrier band.
  function automatic logic in_band(int cnt, int lo, int hi);
    return (cnt > lo) && (cnt < hi);
  endfunction

endpackage

// File: rtl/sbr_sync.sv
module sbr_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_pulse
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign edge_pulse = sync_q ^ prev_q;
endmodule

// File: rtl/sbr_timebase.sv
module sbr_timebase #(
  parameter int CLK_PER_TICK = 32,
  parameter int LEAD_TICKS   = 490,
  parameter int WIN_TICKS    = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic in_win,
  output logic lead_done,
  output logic win_end
);
  localparam int PW   = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam int TMAX = (LEAD_TICKS > WIN_TICKS) ? LEAD_TICKS : WIN_TICKS;
  localparam int TW   = $clog2(TMAX + 1);

  logic [PW-1:0] presc_q;
  logic [TW-1:0] ticks_q;
  logic          tick_stb;

  assign tick_stb  = run && (presc_q == PW'(CLK_PER_TICK - 1));
  assign lead_done = tick_stb && !in_win && (ticks_q == TW'(LEAD_TICKS - 1));
  assign win_end   = tick_stb &&  in_win && (ticks_q == TW'(WIN_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run) begin
      presc_q <= '0;
      ticks_q <= '0;
    end else begin
      presc_q <= tick_stb ? '0 : presc_q + PW'(1);
      if (lead_done || win_end)
        ticks_q <= '0;
      else if (tick_stb)
        ticks_q <= ticks_q + TW'(1);
    end
  end
endmodule

// File: rtl/sbr_edge_counter.sv
module sbr_edge_counter #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         count_en,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_incl
);
  // Saturating increment: stops at all-ones.
  assign cnt_incl = (count_en && (cnt != {W{1'b1}})) ? cnt + W'(1) : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear)
      cnt <= '0;
    else
      cnt <= cnt_incl;
  end
endmodule

// File: rtl/subcarrier_bit_rx.sv
module subcarrier_bit_rx
  import sbr_pkg::*;
#(
  parameter int CLK_PER_TICK = 32,
  parameter int LEAD_TICKS   = 490,
  parameter int WIN_TICKS    = 150,
  parameter int EDGE_LO      = 20,
  parameter int EDGE_HI      = 60,
  parameter int MAX_BITS     = 16,
  parameter int REQ_W        = 5,
  localparam int BITS_W      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_async,
  input  logic                start,
  input  logic [REQ_W-1:0]    bits_req,
  input  logic                decrypt_en,
  input  logic [MAX_BITS-1:0] keystream,
  output logic [MAX_BITS-1:0] rx_data,
  output logic [BITS_W-1:0]   rx_bits,
  output logic                rx_done
);
  localparam int IDX_W  = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;
  localparam int EDGE_W = $clog2(EDGE_HI + 1) + 1;

  rx_state_e             state_q;
  logic [BITS_W-1:0]     len_q, len_now;
  logic [MAX_BITS-1:0]   ks_q, len_mask;
  logic [MAX_BITS-1:0]   shreg_q, shreg_nx;
  logic [IDX_W-1:0]      idx_q;

  // Named internal events (observed by the bound checker).
  logic              edge_seen;
  logic              lead_done;
  logic              win_end;
  logic              in_win;
  logic              bit_val;
  logic [EDGE_W-1:0] edge_cnt, edge_cnt_incl;

  assign in_win  = (state_q == RX_WIN);
  assign len_now = BITS_W'(clamp_len(int'(bits_req), MAX_BITS));
  assign bit_val = in_band(int'(edge_cnt_incl), EDGE_LO, EDGE_HI);

  always_comb begin
    for (int i = 0; i < MAX_BITS; i++)
      len_mask[i] = (i < int'(len_now));
  end

  always_comb begin
    shreg_nx        = shreg_q;
    shreg_nx[idx_q] = bit_val;
  end

  sbr_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_in   (line_async),
    .edge_pulse (edge_seen)
  );

  sbr_timebase #(
    .CLK_PER_TICK (CLK_PER_TICK),
    .LEAD_TICKS   (LEAD_TICKS),
    .WIN_TICKS    (WIN_TICKS)
  ) u_timebase (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (start),
    .run       (state_q != RX_IDLE),
    .in_win    (in_win),
    .lead_done (lead_done),
    .win_end   (win_end)
  );

  sbr_edge_counter #(
    .W (EDGE_W)
  ) u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start || lead_done || win_end),
    .count_en (in_win && edge_seen),
    .cnt      (edge_cnt),
    .cnt_incl (edge_cnt_incl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      len_q   <= '0;
      ks_q    <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      rx_data <= '0;
      rx_bits <= '0;
      rx_done <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (start) begin
        len_q   <= len_now;
        ks_q    <= decrypt_en ? (keystream & len_mask) : '0;
        idx_q   <= '0;
        shreg_q <= '0;
        if (len_now == '0) begin
          rx_data <= '0;
          rx_bits <= '0;
          rx_done <= 1'b1;
          state_q <= RX_IDLE;
        end else begin
          state_q <= RX_LEAD;
        end
      end else begin
        case (state_q)
          RX_LEAD: if (lead_done) state_q <= RX_WIN;
          RX_WIN: begin
            if (win_end) begin
              shreg_q <= shreg_nx;
              if (BITS_W'(idx_q) + BITS_W'(1) == len_q) begin
                rx_data <= shreg_nx ^ ks_q;
                rx_bits <= len_q;
                rx_done <= 1'b1;
                state_q <= RX_IDLE;
              end else begin
                idx_q <= idx_q + IDX_W'(1);
              end
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sbr_checks.sv
module sbr_checks #(
  parameter int MAX_BITS = 16,
  parameter int BITS_W   = 5,
  parameter int EDGE_W   = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                rx_done,
  input logic [MAX_BITS-1:0] rx_data,
  input logic [BITS_W-1:0]   rx_bits,
  input logic                in_win,
  input logic                lead_done,
  input logic                win_end,
  input logic [EDGE_W-1:0]   edge_cnt
);
  // R1: reception windows only begin at the end of the lead-in interval
  p_win_after_lead_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_win) |-> $past(lead_done));

  // R4: within a window the edge count never falls
  p_count_monotonic_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && !win_end && !start) |=> (edge_cnt >= $past(edge_cnt)));

  // R4: a saturated count stays saturated
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && !win_end && !start && (edge_cnt == {EDGE_W{1'b1}}))
      |=> (edge_cnt == {EDGE_W{1'b1}}));

  // R5: reported length never exceeds the cap
  p_len_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rx_bits) <= MAX_BITS);

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !start) |=> !rx_done);

  // R9: bits beyond the reported length are zero
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> ((rx_data >> rx_bits) == '0));
endmodule

bind subcarrier_bit_rx sbr_checks #(
  .MAX_BITS (MAX_BITS),
  .BITS_W   (BITS_W),
  .EDGE_W   (EDGE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .rx_done   (rx_done),
  .rx_data   (rx_data),
  .rx_bits   (rx_bits),
  .in_win    (in_win),
  .lead_done (lead_done),
  .win_end   (win_end),
  .edge_cnt  (edge_cnt)
);

// File: tb/subcarrier_bit_rx_tb.sv
module subcarrier_bit_rx_tb;
  localparam int DIV  = 2;
  localparam int LEAD = 490;
  localparam int WIN  = 150;
  localparam int MAXB = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_async = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  bits_req = '0;
  logic        decrypt_en = 1'b0;
  logic [15:0] keystream = '0;
  logic [15:0] rx_data;
  logic [4:0]  rx_bits;
  logic        rx_done;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  subcarrier_bit_rx #(
    .CLK_PER_TICK (DIV),
    .LEAD_TICKS   (LEAD),
    .WIN_TICKS    (WIN),
    .EDGE_LO      (20),
    .EDGE_HI      (60),
    .MAX_BITS     (MAXB),
    .REQ_W        (5)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_async (line_async),
    .start      (start),
    .bits_req   (bits_req),
    .decrypt_en (decrypt_en),
    .keystream  (keystream),
    .rx_data    (rx_data),
    .rx_bits    (rx_bits),
    .rx_done    (rx_done)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive_windows(input int n, input int counts[16]);
    repeat (LEAD * DIV) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      int gap;
      gap = (counts[k] * 4 <= 240) ? 4 : 1;
      repeat (40) @(negedge clk);
      for (int t = 0; t < counts[k]; t++) begin
        line_async = ~line_async;
        repeat (gap) @(negedge clk);
      end
      repeat (WIN * DIV - 40 - counts[k] * gap) @(negedge clk);
    end
  endtask

  task automatic run_frame(input string tag, input int req, input logic crypt,
                           input logic [15:0] ks, input int counts[16],
                           input int exp_data, input int exp_bits);
    int n, cyc, exp_cyc;
    bit seen;
    n = (req > MAXB) ? MAXB : req;
    exp_cyc = (n == 0) ? 0 : (LEAD + n * WIN) * DIV;
    cyc = 0;
    seen = 0;
    @(negedge clk);
    bits_req = 5'(req); decrypt_en = crypt; keystream = ks; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    keystream = ~ks ^ 16'h3C96;   // R7: post-start changes must not matter
    decrypt_en = ~crypt;
    fork
      drive_windows(n, counts);
      begin
        while (!seen && cyc < exp_cyc + 100) begin
          if (rx_done) seen = 1;
          else begin
            @(posedge clk); cyc++;
            @(negedge clk);
          end
        end
        check_eq({tag, " done seen"}, int'(seen), 1);
        if (seen) begin
          check_eq({tag, " R2 done cycle"}, cyc, exp_cyc);
          check_eq({tag, " data"}, int'(rx_data), exp_data);
          check_eq({tag, " R5 bits"}, int'(rx_bits), exp_bits);
          @(negedge clk);
          check_eq({tag, " R9 done pulse width"}, int'(rx_done), 0);
        end
      end
    join
    check_eq({tag, " R9 data held"}, int'(rx_data), exp_data);
  endtask

  task automatic t_reset;
    check_eq("R11 done after reset", int'(rx_done), 0);
    check_eq("R11 data after reset", int'(rx_data), 0);
    check_eq("R11 bits after reset", int'(rx_bits), 0);
  endtask

  task automatic t_lsb_order;
    // R6/R1: windows 0,2,3,6 carry subcarrier -> 0x4D
    run_frame("R6 lsb first", 8, 1'b0, 16'h0000,
              '{42,0,42,42,0,0,42,0, 0,0,0,0,0,0,0,0}, 'h4D, 8);
  endtask

  task automatic t_band_edges;
    // R3: 20->0, 21->1, 59->1, 60->0
    run_frame("R3 band edges", 4, 1'b0, 16'h0000,
              '{20,21,59,60, 0,0,0,0,0,0,0,0,0,0,0,0}, 'h6, 4);
  endtask

  task automatic t_saturate;
    // R4: 170 edges would wrap to 42 in 7 bits; saturated -> 0
    run_frame("R4 saturation", 2, 1'b0, 16'h0000,
              '{170,42, 0,0,0,0,0,0,0,0,0,0,0,0,0,0}, 'h2, 2);
  endtask

  task automatic t_silent;
    // R8: silent line, keystream given but decrypt off (R7)
    run_frame("R8 silent line", 5, 1'b0, 16'hFFFF,
              '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0}, 'h0, 5);
  endtask

  task automatic t_decrypt;
    // R7: raw 0x25 ^ (0xFFFF masked to 6 bits) = 0x1A
    run_frame("R7 decrypt mask", 6, 1'b1, 16'hFFFF,
              '{42,0,42,0,0,42, 0,0,0,0,0,0,0,0,0,0}, 'h1A, 6);
  endtask

  task automatic t_clamp;
    // R5/R12: request 20 -> 16 bits, issued right after previous done
    run_frame("R5 R12 clamp", 20, 1'b1, 16'h0F0F,
              '{42,0,42,0,42,0,42,0,42,0,42,0,42,0,42,0}, 'h5A5A, 16);
  endtask

  task automatic t_zero_len;
    // R10: zero-length request
    run_frame("R10 zero length", 0, 1'b1, 16'hFFFF,
              '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0}, 'h0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lsb_order();
    t_band_edges();
    t_saturate();
    t_silent();
    t_decrypt();
    t_clamp();
    t_zero_len();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule